// File: doc/BRIEF.md
# Double-Buffered Result List Addresser

This block produces the RAM write address for each conversion result that a sampling converter stores as a list in system memory. Each address is the sum of an even base pointer, the offset of whichever of two lists is active, and a byte index. The index runs through the list two bytes per result. A result-store strobe produces a write strobe and the address in the same cycle. The address is checked against a programmable RAM window before it is used.

In double-buffer mode the two lists alternate, so software can read one list while the converter fills the other. An executed end-of-list command does not swap the lists straight away. It arms a swap, and the swap happens when the first result of the next command list is stored. An abort that returns the sequencer to idle swaps the lists at once. A wake-up from low power never swaps: it cancels any armed swap, and the list that was active before is written again from its start. In single-buffer mode the list select never moves. A write outside the window is blocked. It raises a sticky error flag, which can also drive an interrupt.

Top module: `rvl_addr_gen`

## Requirements
- R1: While `res_store` is high, `wr_addr` equals the low AW bits of even base + active offset (`cfg_off1` when the effective select is 1, otherwise `cfg_off0`) + the zero-extended index. `wr_en` is high in that same cycle when the address is in range.
- R2: Bit 0 of `cfg_base` has no effect on `wr_addr`.
- R3: With `cfg_dbuf` low, `list_sel` keeps its value across all events, and `ev_eol` arms nothing.
- R4: With `cfg_dbuf` high, `ev_eol` arms a swap. The swap takes effect on the first `res_store` after the next `ev_list_start`. That store already uses the other list, and `list_sel` shows the new list from the following cycle.
- R5: With `cfg_dbuf` high, `ev_abort_idle` inverts `list_sel` in the next cycle. It also clears the index and the armed swap. Abort has priority over every other event in the same cycle.
- R6: `ev_lp_exit` never changes `list_sel`. It clears the armed swap and the index.
- R7: The index returns to 0 after `ev_list_start`, after an abort and after a low-power exit. Otherwise it advances by 2 after each `res_store` and wraps at 2^IDXW. `ev_list_start` wins over a store in the same cycle.
- R8: An address is out of range when it is below `cfg_ram_lo`, above `cfg_ram_hi`, or when the sum carries beyond AW bits. A store to such an address keeps `wr_en` low and sets `err_flag`.
- R9: `err_flag` stays set until an `err_clr` pulse clears it. A new error in the same cycle as the clear wins.
- R10: `err_irq` is high exactly when `err_flag` and `cfg_err_ie` are both high.
- R11: After reset, `list_sel`, `err_flag`, the index and the armed swap are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dbuf | input | 1 | 1 = double-buffer mode, 0 = single list |
| cfg_base | input | AW | Base pointer; bit 0 is ignored |
| cfg_off0 | input | AW | Offset of list 0 |
| cfg_off1 | input | AW | Offset of list 1 |
| cfg_ram_lo | input | AW | Lowest legal address |
| cfg_ram_hi | input | AW | Highest legal address |
| cfg_err_ie | input | 1 | Error interrupt enable |
| ev_eol | input | 1 | End-of-list command executed |
| ev_list_start | input | 1 | New command list started from its top |
| ev_abort_idle | input | 1 | List aborted, sequencer back to idle |
| ev_lp_exit | input | 1 | Exit from low-power mode |
| res_store | input | 1 | A result is being stored this cycle |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| wr_addr | output | AW | Result write address |
| wr_en | output | 1 | Result write strobe |
| list_sel | output | 1 | Active list |
| err_flag | output | 1 | Sticky illegal-access flag |
| err_irq | output | 1 | Error interrupt |

## Verification
Some properties are checked on every cycle. In single-buffer mode the select holds. The select only moves on a deferred swap or an abort, and an abort always inverts it. A list start zeroes the index. An out-of-range address never produces a write strobe, and the error flag sets on such a store and holds until it is cleared. Other behaviour can only be shown by the bench's scenarios, with its reference model compared every clock. These are the exact address sums, that the armed swap waits for the first store of the next list, that a low-power wake-up cancels it, the carry case of the window check, and the priority of a set over a clear.

// File: rtl/rla_pkg.sv
package rla_pkg;
  // Sequencer control class for one cycle, in priority order
  typedef enum logic [1:0] {
    CTL_NORMAL = 2'd0,
    CTL_LPEXIT = 2'd1,
    CTL_ABORT  = 2'd2
  } rla_ctl_e;

  localparam int unsigned RLA_STEP = 2;  // bytes per stored result
endpackage

// File: rtl/rla_evt_decode.sv
module rla_evt_decode
  import rla_pkg::*;
(
  input  logic     abort_idle,
  input  logic     lp_exit,
  output rla_ctl_e ctl
);
  always_comb begin
    if (abort_idle)   ctl = CTL_ABORT;
    else if (lp_exit) ctl = CTL_LPEXIT;
    else              ctl = CTL_NORMAL;
  end
endmodule

// File: rtl/rla_list_ctrl.sv
module rla_list_ctrl
  import rla_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dbuf,
  input  rla_ctl_e ctl,
  input  logic     eol,
  input  logic     list_start,
  input  logic     store,
  output logic     sel_q,
  output logic     sel_eff,
  output logic     swap_now,
  output logic     abort_swap
);
  logic armed_q;
  logic first_q;

  assign swap_now   = store & first_q & armed_q & dbuf & (ctl == CTL_NORMAL);
  assign abort_swap = dbuf & (ctl == CTL_ABORT);
  assign sel_eff    = sel_q ^ swap_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      armed_q <= 1'b0;
      first_q <= 1'b0;
    end else begin
      unique case (ctl)
        CTL_ABORT: begin
          sel_q   <= sel_q ^ dbuf;
          armed_q <= 1'b0;
          first_q <= 1'b0;
        end
        CTL_LPEXIT: begin
          armed_q <= 1'b0;
          first_q <= 1'b0;
        end
        default: begin
          sel_q   <= sel_eff;
          armed_q <= (armed_q & ~swap_now) | (eol & dbuf);
          first_q <= list_start | (first_q & ~store);
        end
      endcase
    end
  end
endmodule

// File: rtl/rla_index.sv
module rla_index
  import rla_pkg::*;
#(
  parameter int unsigned IDXW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rla_ctl_e        ctl,
  input  logic            list_start,
  input  logic            store,
  output logic [IDXW-1:0] idx_q
);
  localparam logic [IDXW-1:0] STEP = IDXW'(RLA_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idx_q <= '0;
    else if (ctl != CTL_NORMAL)  idx_q <= '0;
    else if (list_start)         idx_q <= '0;
    else if (store)              idx_q <= idx_q + STEP;
  end
endmodule

// File: rtl/rla_addr_chk.sv
module rla_addr_chk #(
  parameter int unsigned AW   = 24,
  parameter int unsigned IDXW = 10
) (
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   off0,
  input  logic [AW-1:0]   off1,
  input  logic            sel,
  input  logic [IDXW-1:0] idx,
  input  logic [AW-1:0]   lo,
  input  logic [AW-1:0]   hi,
  output logic [AW-1:0]   addr,
  output logic            oor
);
  localparam int unsigned SW = AW + 2;

  function automatic logic [SW-1:0] list_sum(
    input logic [AW-1:0] b, input logic [AW-1:0] o, input logic [IDXW-1:0] i);
    logic [SW-1:0] eb;
    eb = SW'({b[AW-1:1], 1'b0});
    return eb + SW'(o) + SW'(i);
  endfunction

  function automatic logic outside(
    input logic [SW-1:0] s, input logic [AW-1:0] l, input logic [AW-1:0] h);
    return (s[SW-1:AW] != '0) || (s[AW-1:0] < l) || (s[AW-1:0] > h);
  endfunction

  logic [SW-1:0] sum;
  assign sum  = list_sum(base, sel ? off1 : off0, idx);
  assign addr = sum[AW-1:0];
  assign oor  = outside(sum, lo, hi);
endmodule

// File: rtl/rvl_addr_gen.sv
module rvl_addr_gen
  import rla_pkg::*;
#(
  parameter int unsigned AW   = 24,
  parameter int unsigned IDXW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dbuf,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_off0,
  input  logic [AW-1:0] cfg_off1,
  input  logic [AW-1:0] cfg_ram_lo,
  input  logic [AW-1:0] cfg_ram_hi,
  input  logic          cfg_err_ie,
  input  logic          ev_eol,
  input  logic          ev_list_start,
  input  logic          ev_abort_idle,
  input  logic          ev_lp_exit,
  input  logic          res_store,
  input  logic          err_clr,
  output logic [AW-1:0] wr_addr,
  output logic          wr_en,
  output logic          list_sel,
  output logic          err_flag,
  output logic          err_irq
);
  rla_ctl_e        ctl;
  logic            sel_eff;
  logic            swap_now;
  logic            abort_swap;
  logic [IDXW-1:0] idx_q;
  logic            addr_oor;
  logic            err_set;

  rla_evt_decode u_dec (
    .abort_idle (ev_abort_idle),
    .lp_exit    (ev_lp_exit),
    .ctl        (ctl)
  );

  rla_list_ctrl u_lst (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbuf       (cfg_dbuf),
    .ctl        (ctl),
    .eol        (ev_eol),
    .list_start (ev_list_start),
    .store      (res_store),
    .sel_q      (list_sel),
    .sel_eff    (sel_eff),
    .swap_now   (swap_now),
    .abort_swap (abort_swap)
  );

  rla_index #(.IDXW(IDXW)) u_idx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .list_start (ev_list_start),
    .store      (res_store),
    .idx_q      (idx_q)
  );

  rla_addr_chk #(.AW(AW), .IDXW(IDXW)) u_chk (
    .base (cfg_base),
    .off0 (cfg_off0),
    .off1 (cfg_off1),
    .sel  (sel_eff),
    .idx  (idx_q),
    .lo   (cfg_ram_lo),
    .hi   (cfg_ram_hi),
    .addr (wr_addr),
    .oor  (addr_oor)
  );

  assign wr_en   = res_store & ~addr_oor;
  assign err_set = res_store & addr_oor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (err_set) err_flag <= 1'b1;
    else if (err_clr) err_flag <= 1'b0;
  end

  assign err_irq = err_flag & cfg_err_ie;
endmodule

// File: rtl/rla_checker.sv
module rla_checker #(
  parameter int unsigned IDXW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_dbuf,
  input logic            res_store,
  input logic            err_clr,
  input logic            ev_list_start,
  input logic            wr_en,
  input logic            list_sel,
  input logic            err_flag,
  input logic            swap_now,
  input logic            abort_swap,
  input logic            addr_oor,
  input logic [IDXW-1:0] idx_q
);
  p_single_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dbuf |=> $stable(list_sel));

  p_sel_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_now || abort_swap) |=> $stable(list_sel));

  p_abort_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_swap |=> (list_sel != $past(list_sel)));

  p_idx_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_list_start |=> (idx_q == '0));

  p_oor_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oor |-> !wr_en);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_store && addr_oor) |=> err_flag);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind rvl_addr_gen rla_checker #(.IDXW(IDXW)) u_rla_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_dbuf      (cfg_dbuf),
  .res_store     (res_store),
  .err_clr       (err_clr),
  .ev_list_start (ev_list_start),
  .wr_en         (wr_en),
  .list_sel      (list_sel),
  .err_flag      (err_flag),
  .swap_now      (swap_now),
  .abort_swap    (abort_swap),
  .addr_oor      (addr_oor),
  .idx_q         (idx_q)
);

// File: tb/rvl_addr_gen_bench.sv
module rvl_addr_gen_bench;
  localparam int AW   = 16;
  localparam int IDXW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_dbuf = 1'b0, cfg_err_ie = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_off0 = '0, cfg_off1 = '0;
  logic [AW-1:0] cfg_ram_lo = '0, cfg_ram_hi = '0;
  logic          ev_eol = 0, ev_list_start = 0, ev_abort_idle = 0, ev_lp_exit = 0;
  logic          res_store = 0, err_clr = 0;
  logic [AW-1:0] wr_addr;
  logic          wr_en, list_sel, err_flag, err_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_sel = 0, m_armed = 0, m_first = 0, m_idx = 0, m_err = 0;

  always #2 clk = ~clk;

  rvl_addr_gen #(.AW(AW), .IDXW(IDXW)) u_rvl_addr_gen (.*);

  task automatic check(input string tag, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle of inputs, compare, advance the model across the next edge
  task automatic step(input string tag, input bit eol, input bit ls, input bit ab,
                      input bit lp, input bit st, input bit clr);
    longint total;
    int     swap, use1, oor;
    ev_eol = eol; ev_list_start = ls; ev_abort_idle = ab;
    ev_lp_exit = lp; res_store = st; err_clr = clr;
    #1;
    swap  = (st && m_first && m_armed && cfg_dbuf && !ab && !lp) ? 1 : 0;
    use1  = (m_sel + swap) % 2;
    total = longint'(cfg_base) / 2 * 2 + (use1 ? longint'(cfg_off1) : longint'(cfg_off0)) + m_idx;
    oor   = (total >= (longint'(1) << AW) || total < cfg_ram_lo || total > cfg_ram_hi) ? 1 : 0;
    if (st) check(tag, wr_addr, total % (longint'(1) << AW), "wr_addr");
    check(tag, wr_en, (st && !oor) ? 1 : 0, "wr_en");
    check(tag, list_sel, m_sel, "list_sel");
    check(tag, err_flag, m_err, "err_flag");
    check(tag, err_irq, (m_err && cfg_err_ie) ? 1 : 0, "err_irq");
    // model update
    if (st && oor) m_err = 1; else if (clr) m_err = 0;
    if (ab) begin
      if (cfg_dbuf) m_sel = 1 - m_sel;
      m_armed = 0; m_first = 0; m_idx = 0;
    end else if (lp) begin
      m_armed = 0; m_first = 0; m_idx = 0;
    end else begin
      if (swap) begin m_sel = 1 - m_sel; m_armed = 0; end
      if (eol && cfg_dbuf) m_armed = 1;
      if (ls) begin m_idx = 0; m_first = 1; end
      else if (st) begin m_idx = (m_idx + 2) % (1 << IDXW); m_first = 0; end
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_base = 16'h1001;  // odd base: bit 0 ignored (R2)
    cfg_off0 = 16'h0100;
    cfg_off1 = 16'h0400;
    cfg_ram_lo = 16'h1000;
    cfg_ram_hi = 16'h1FFF;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", list_sel, 0, "list_sel");
    check("R11", err_flag, 0, "err_flag");
    rst_n = 1'b1;
    @(negedge clk);

    // R3: single-buffer, list 0 only; R1/R7 address walk
    cfg_dbuf = 0;
    step("R3", 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R1", 0, 0, 0, 0, 1, 0);
    step("R3", 1, 0, 0, 0, 0, 0);
    step("R3", 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R3", 0, 0, 0, 0, 1, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    idle("R3", 2);

    // R4: deferred swap in double-buffer mode
    cfg_dbuf = 1;
    step("R4", 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R4", 0, 0, 0, 0, 1, 0);
    step("R4", 1, 0, 0, 0, 0, 0);
    idle("R4", 2);
    step("R4", 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R4", 0, 0, 0, 0, 1, 0);
    step("R4", 1, 0, 0, 0, 0, 0);
    step("R4", 0, 1, 0, 0, 1, 0);   // start wins over a store (R7)
    for (int i = 0; i < 2; i++) step("R7", 0, 0, 0, 0, 1, 0);

    // R5: abort swaps at once, even with other events
    step("R5", 1, 1, 1, 1, 1, 0);
    for (int i = 0; i < 2; i++) step("R5", 0, 0, 0, 0, 1, 0);

    // R6: armed swap cancelled by low-power exit
    step("R6", 1, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R6", 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R6", 0, 0, 0, 0, 1, 0);

    // R7: index wrap
    step("R7", 0, 1, 0, 0, 0, 0);
    cfg_ram_hi = 16'hFFFF;
    for (int i = 0; i < 130; i++) step("R7", 0, 0, 0, 0, 1, 0);
    cfg_ram_hi = 16'h1FFF;

    // R8/R10: above window, irq enabled
    cfg_err_ie = 1;
    cfg_ram_hi = 16'h1102;
    step("R8", 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R8", 0, 0, 0, 0, 1, 0);
    idle("R9", 2);
    step("R9", 0, 0, 0, 0, 0, 1);
    idle("R10", 1);
    // R9: set wins over clear
    step("R9", 0, 0, 0, 0, 1, 1);
    idle("R9", 1);
    cfg_err_ie = 0;
    idle("R10", 1);
    step("R9", 0, 0, 0, 0, 0, 1);
    // below window
    cfg_ram_hi = 16'h1FFF;
    cfg_ram_lo = 16'h1500;
    step("R8", 0, 1, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 1);
    // carry beyond AW bits
    cfg_ram_lo = 16'h0000;
    cfg_ram_hi = 16'hFFFF;
    cfg_base = 16'hFF01;
    step("R8", 0, 1, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0);
    step("R2", 0, 0, 0, 0, 0, 1);
    cfg_base = 16'h0003;
    step("R2", 0, 0, 0, 0, 1, 0);
    idle("R1", 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule